// File: doc/BRIEF.md
# Acquisition Sample Buffer with Status and Interrupt

This block sits between an analog scan sequencer and a host register port. Each tagged sample the sequencer delivers is stored in a first-in, first-out buffer, and the host drains it one word per read of the data address. A status word reports whether the buffer is empty, at least half full or full, and whether an interrupt is pending. The interrupt can be raised for every stored sample, or once each time the fill level crosses the half-way mark, so the host can pick between low latency and block transfers.

The host controls the block through a control register. That register enables the interrupt output, selects the interrupt mode, and gates the three convert-trigger sources (software, internal pacer, external) before they reach the sequencer. It also carries the clock-source select for the first pacer counter. Separate write strobes empty the buffer and drop the pending interrupt. A buffer that has filled is treated as a fatal overflow: it stops storing until it is cleared.

Top module: `acqf_top`

## Requirements
- R1: After reset the status word reads 0x0100 (only the empty bit set), the control register is zero, and `irq`, `conv_trig` and `cnt0_ext_clk` are low.
- R2: A host read of address 0 with `rd_en` high returns the oldest stored sample and removes it, so samples leave in arrival order.
- R3: A read of address 1 returns the status word: bit 8 empty (count 0), bit 9 half (count at least DEPTH/2), bit 10 full, bit 11 interrupt pending, and all other bits zero.
- R4: Once the count reaches DEPTH, the full bit is set and incoming samples are dropped. The full bit stays set through any number of host reads until the buffer is cleared.
- R5: With control bit 5 clear, every sample actually stored sets the pending bit.
- R6: With control bit 5 set, the pending bit is set only by a store that takes the count from DEPTH/2-1 to DEPTH/2. It is not set again until the count has fallen below DEPTH/2 and crossed the threshold once more.
- R7: A write of any value to address 2 clears the pending bit. A write of any value to address 3 empties the buffer and releases the full bit, and leaves the pending bit unchanged.
- R8: `irq` is high exactly when the pending bit is set and control bit 4 is set. Pending still records events while bit 4 is clear.
- R9: `conv_trig` pulses high for one cycle, one clock after a write to address 0 when control bit 0 is set, after a `pacer_tick` when bit 1 is set, or after an `ext_trig` when bit 2 is set. A source whose bit is clear produces no pulse.
- R10: Control bit 6 drives `cnt0_ext_clk`. Writing zero to the control register (address 1) removes every trigger source and the interrupt output.
- R11: A data read while the buffer is empty returns zero and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe from the sequencer |
| smp_data | input | DATA_W | Tagged sample word |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 soft trigger, 1 control, 2 clear interrupt, 3 clear buffer) |
| ctl_wdata | input | 7 | Host write data for the control register |
| rd_en | input | 1 | Host read strobe; pops the buffer on address 0 |
| rd_addr | input | 2 | Host read address (0 data, 1 status) |
| rd_data | output | DATA_W | Combinational read data |
| pacer_tick | input | 1 | Internal pacer convert pulse |
| ext_trig | input | 1 | External convert pulse |
| conv_trig | output | 1 | Gated convert trigger to the sequencer |
| irq | output | 1 | Interrupt request |
| cnt0_ext_clk | output | 1 | Counter 0 clock select, high for external |

## Verification
Stores, clears and control writes take effect at the clock edge that samples them. Status, `irq` and `cnt0_ext_clk` are therefore correct one edge after the stimulus, and the bench checks them just after that edge. Read data is combinational, so it is captured in the same cycle as the read, before the edge that pops the word. `conv_trig` passes through one register: it is checked just after the edge that samples a trigger, and checked low one cycle later. Every fill level of a 16-entry configuration is stepped through, and each status word is compared with a value computed from the count.

// File: rtl/acqf_pkg.sv
package acqf_pkg;
   localparam int CTRL_W     = 7;
   localparam int ST_EMPTY   = 8;
   localparam int ST_HALF    = 9;
   localparam int ST_FULL    = 10;
   localparam int ST_PEND    = 11;
   localparam int CB_SOFT    = 0;
   localparam int CB_PACER   = 1;
   localparam int CB_EXT     = 2;
   localparam int CB_IRQEN   = 4;
   localparam int CB_HALFIRQ = 5;
   localparam int CB_CNT0EXT = 6;
   localparam int N_TRIG     = 3;

   typedef enum logic [1:0] {
      A_DATA    = 2'd0,
      A_CTRL    = 2'd1,
      A_CLRIRQ  = 2'd2,
      A_CLRFIFO = 2'd3
   } acqf_addr_e;
endpackage

// File: rtl/acqf_store.sv
module acqf_store #(
   parameter int DATA_W     = 16,
   parameter int DEPTH_LOG2 = 10,
   localparam int CNT_W     = DEPTH_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic              flush,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full_flag,
   output logic              half_flag,
   output logic              stored,
   output logic              half_rise
);
   localparam int DEPTH = 1 << DEPTH_LOG2;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

   logic [DATA_W-1:0]     mem [DEPTH];
   logic [DEPTH_LOG2-1:0] wptr, rptr;
   logic [CNT_W-1:0]      cnt_nxt;
   logic                  do_store, do_pop;

   assign do_store = push_req && !full_flag && !flush;
   assign do_pop   = pop_req && (count != '0) && !flush;

   always_comb begin
      if (flush) cnt_nxt = '0;
      else begin
         case ({do_store, do_pop})
            2'b10:   cnt_nxt = count + 1'b1;
            2'b01:   cnt_nxt = count - 1'b1;
            default: cnt_nxt = count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr      <= '0;
         rptr      <= '0;
         count     <= '0;
         full_flag <= 1'b0;
      end else begin
         count <= cnt_nxt;
         if (flush) begin
            wptr      <= '0;
            rptr      <= '0;
            full_flag <= 1'b0;
         end else begin
            if (do_store) wptr <= wptr + 1'b1;
            if (do_pop)   rptr <= rptr + 1'b1;
            if (cnt_nxt == FULL_CNT) full_flag <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_store) mem[wptr] <= din;
   end

   assign head      = (count == '0) ? '0 : mem[rptr];
   assign half_flag = (count >= HALF_CNT);
   assign stored    = do_store;
   assign half_rise = (count < HALF_CNT) && (cnt_nxt >= HALF_CNT);
endmodule

// File: rtl/acqf_ctrl.sv
module acqf_ctrl
   import acqf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              soft_hit,
   input  logic              pacer_tick,
   input  logic              ext_trig,
   output logic [CTRL_W-1:0] ctrl,
   output logic              conv_trig
);
   logic [N_TRIG-1:0] src, gated;

   assign src = {ext_trig, pacer_tick, soft_hit};

   for (genvar g = 0; g < N_TRIG; g++) begin : g_gate
      assign gated[g] = src[g] & ctrl[CB_SOFT + g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl      <= '0;
         conv_trig <= 1'b0;
      end else begin
         conv_trig <= |gated;
         if (ctrl_we) ctrl <= ctrl_wdata;
      end
   end
endmodule

// File: rtl/acqf_irq.sv
module acqf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic half_mode,
   input  logic irq_en,
   input  logic stored,
   input  logic half_rise,
   input  logic clr_pend,
   output logic pending,
   output logic irq
);
   logic set_ev;

   assign set_ev = half_mode ? half_rise : stored;

   always_ff @(posedge clk) begin
      if (!rst_n)        pending <= 1'b0;
      else if (set_ev)   pending <= 1'b1;
      else if (clr_pend) pending <= 1'b0;
   end

   assign irq = pending & irq_en;
endmodule

// File: rtl/acqf_top.sv
module acqf_top
   import acqf_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int DEPTH_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CTRL_W-1:0] ctl_wdata,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pacer_tick,
   input  logic              ext_trig,
   output logic              conv_trig,
   output logic              irq,
   output logic              cnt0_ext_clk
);
   localparam int CNT_W = DEPTH_LOG2 + 1;

   if (DATA_W < ST_PEND + 1) begin : g_bad_width
      $error("acqf_top: DATA_W must hold the status bits");
   end
   if (DEPTH_LOG2 < 2) begin : g_bad_depth
      $error("acqf_top: DEPTH_LOG2 must be at least 2");
   end

   logic [CTRL_W-1:0] ctrl;
   logic [DATA_W-1:0] head;
   logic [CNT_W-1:0]  count;
   logic full_flag, half_flag, stored, half_rise, pending;
   logic wr_soft, wr_ctrl, wr_clrirq, wr_clrfifo, rd_pop;

   assign wr_soft    = wr_en && (wr_addr == A_DATA);
   assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
   assign wr_clrirq  = wr_en && (wr_addr == A_CLRIRQ);
   assign wr_clrfifo = wr_en && (wr_addr == A_CLRFIFO);
   assign rd_pop     = rd_en && (rd_addr == A_DATA);

   acqf_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
      .clk(clk), .rst_n(rst_n), .push_req(smp_valid), .pop_req(rd_pop),
      .flush(wr_clrfifo), .din(smp_data), .head(head), .count(count),
      .full_flag(full_flag), .half_flag(half_flag), .stored(stored),
      .half_rise(half_rise)
   );

   acqf_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(wr_ctrl), .ctrl_wdata(ctl_wdata),
      .soft_hit(wr_soft), .pacer_tick(pacer_tick), .ext_trig(ext_trig),
      .ctrl(ctrl), .conv_trig(conv_trig)
   );

   acqf_irq u_irq (
      .clk(clk), .rst_n(rst_n), .half_mode(ctrl[CB_HALFIRQ]),
      .irq_en(ctrl[CB_IRQEN]), .stored(stored), .half_rise(half_rise),
      .clr_pend(wr_clrirq), .pending(pending), .irq(irq)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_DATA: rd_data = head;
         A_CTRL: begin
            rd_data[ST_EMPTY] = (count == '0);
            rd_data[ST_HALF]  = half_flag;
            rd_data[ST_FULL]  = full_flag;
            rd_data[ST_PEND]  = pending;
         end
         default: rd_data = '0;
      endcase
   end

   assign cnt0_ext_clk = ctrl[CB_CNT0EXT];
endmodule

// File: rtl/acqf_checker.sv
module acqf_checker
   import acqf_pkg::*;
#(
   parameter int DEPTH_LOG2 = 10,
   localparam int CNT_W     = DEPTH_LOG2 + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [CTRL_W-1:0] ctl_wdata,
   input logic              rd_en,
   input logic [1:0]        rd_addr,
   input logic              smp_valid,
   input logic              irq,
   input logic              conv_trig,
   input logic [CNT_W-1:0]  count,
   input logic              full_flag,
   input logic              pending,
   input logic [CTRL_W-1:0] ctrl
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << DEPTH_LOG2);
   logic clr_fifo, clr_irq, pop;
   assign clr_fifo = wr_en && (wr_addr == A_CLRFIFO);
   assign clr_irq  = wr_en && (wr_addr == A_CLRIRQ);
   assign pop      = rd_en && (rd_addr == A_DATA) && (count != '0);

   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      full_flag && !clr_fifo |=> full_flag);
   a_r4_no_store_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      full_flag && !pop && !clr_fifo |=> $stable(count));
   a_r3_empty_not_full_before: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) && !full_flag && !smp_valid && !clr_fifo |=> (count == '0));
   a_r7_clear_fifo: assert property (@(posedge clk) disable iff (!rst_n)
      clr_fifo |=> (count == '0) && !full_flag);
   a_r7_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
      clr_irq && !smp_valid |=> !pending);
   a_r9_soft_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == A_DATA) && ctrl[CB_SOFT] |=> conv_trig);
   a_r10_zero_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == A_CTRL) && (ctl_wdata == '0) |=> !irq);
endmodule

bind acqf_top acqf_checker #(.DEPTH_LOG2(DEPTH_LOG2)) u_acqf_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .ctl_wdata(ctl_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
   .smp_valid(smp_valid), .irq(irq), .conv_trig(conv_trig), .count(count),
   .full_flag(full_flag), .pending(pending), .ctrl(ctrl)
);

// File: tb/tb_acqf_top.sv
module tb_acqf_top;
   localparam int DW = 16;
   localparam int DL = 4;
   localparam int DEPTH = 1 << DL;
   localparam int HALF = DEPTH / 2;

   logic clk = 0, rst_n = 0;
   logic smp_valid = 0, wr_en = 0, rd_en = 0, pacer_tick = 0, ext_trig = 0;
   logic [DW-1:0] smp_data = '0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [6:0] ctl_wdata = '0;
   logic [DW-1:0] rd_data;
   logic conv_trig, irq, cnt0_ext_clk;
   int total = 0, bad = 0;
   logic [DW-1:0] got;

   acqf_top #(.DATA_W(DW), .DEPTH_LOG2(DL)) dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .ctl_wdata(ctl_wdata), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .pacer_tick(pacer_tick),
      .ext_trig(ext_trig), .conv_trig(conv_trig), .irq(irq),
      .cnt0_ext_clk(cnt0_ext_clk)
   );

   always #5 clk = ~clk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] st(int k, bit full, bit pend);
      return 16'((k == 0) << 8 | (k >= HALF) << 9 | int'(full) << 10 | int'(pend) << 11);
   endfunction

   task automatic push(logic [DW-1:0] v);
      @(negedge clk); smp_valid = 1; smp_data = v;
      @(posedge clk); #1 smp_valid = 0;
   endtask

   task automatic wr(logic [1:0] a, logic [6:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; ctl_wdata = d;
      @(posedge clk); #1 wr_en = 0;
   endtask

   task automatic rd(logic [1:0] a, bit pop, output logic [DW-1:0] v);
      @(negedge clk); rd_addr = a; rd_en = pop;
      #1 v = rd_data;
      @(posedge clk); #1 rd_en = 0;
   endtask

   task automatic pulse(int sel);
      @(negedge clk);
      if (sel == 1) pacer_tick = 1; else ext_trig = 1;
      @(posedge clk); #1 pacer_tick = 0; ext_trig = 0;
   endtask

   initial begin
      #2_000_000;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      rd(2'd1, 0, got); chk("R1 status", got, 16'h0100);
      chk("R1 irq", irq, 0); chk("R1 conv", conv_trig, 0); chk("R1 cnt0", cnt0_ext_clk, 0);
      // R11 empty read
      rd(2'd0, 1, got); chk("R11 data", got, 0);
      rd(2'd1, 0, got); chk("R11 status", got, 16'h0100);
      // R3 / R4 fill sweep, per-sample mode, irq disabled
      for (int k = 1; k <= DEPTH; k++) begin
         push(16'hA000 + 16'(k));
         rd(2'd1, 0, got); chk("R3 fill status", got, st(k, k == DEPTH, 1));
      end
      for (int k = 0; k < 3; k++) push(16'hBEEF);
      rd(2'd1, 0, got); chk("R4 full after drops", got, st(DEPTH, 1, 1));
      // R2 drain in order, R4 full sticks
      for (int k = 1; k <= DEPTH; k++) begin
         rd(2'd0, 1, got); chk("R2 order", got, 16'hA000 + 16'(k));
         rd(2'd1, 0, got); chk("R4 full sticky", got, st(DEPTH - k, 1, 1));
      end
      // R7 clear buffer keeps pending; clear irq
      wr(2'd3, 7'h55); rd(2'd1, 0, got); chk("R7 clrfifo", got, 16'h0900);
      wr(2'd2, 7'h00); rd(2'd1, 0, got); chk("R7 clrirq", got, 16'h0100);
      // R5 / R8 per-sample interrupt
      wr(2'd1, 7'h10); chk("R8 no pend", irq, 0);
      push(16'h1111); chk("R5 irq per sample", irq, 1);
      wr(2'd2, 7'h00); chk("R7 irq dropped", irq, 0);
      wr(2'd1, 7'h00); push(16'h2222); chk("R8 masked", irq, 0);
      rd(2'd1, 0, got); chk("R8 pend recorded", got[11], 1);
      wr(2'd1, 7'h10); chk("R8 unmasked", irq, 1);
      wr(2'd2, 7'h00); wr(2'd3, 7'h00);
      // R6 half mode
      wr(2'd1, 7'h30);
      for (int k = 1; k < HALF; k++) begin
         push(16'(k)); chk("R6 below half", irq, 0);
      end
      push(16'h0800); chk("R6 at half", irq, 1);
      wr(2'd2, 7'h00); push(16'h0900); chk("R6 no refire above", irq, 0);
      rd(2'd0, 1, got); rd(2'd0, 1, got);
      chk("R6 below again", irq, 0);
      push(16'h0A00); chk("R6 recross", irq, 1);
      wr(2'd2, 7'h00); wr(2'd3, 7'h00);
      // R9 trigger gating sweep
      for (int en = 0; en < 8; en++) begin
         wr(2'd1, 7'(en));
         @(posedge clk); #1;
         for (int s = 0; s < 3; s++) begin
            if (s == 0) wr(2'd0, 7'h00); else pulse(s);
            chk("R9 gated trigger", conv_trig, (en >> s) & 1);
            @(posedge clk); #1 chk("R9 one cycle", conv_trig, 0);
         end
      end
      // R10 counter clock select and zero control
      wr(2'd1, 7'h57); chk("R10 cnt0 ext", cnt0_ext_clk, 1);
      push(16'h3333); chk("R10 irq live", irq, 1);
      wr(2'd1, 7'h00); chk("R10 cnt0 int", cnt0_ext_clk, 0); chk("R10 irq off", irq, 0);
      wr(2'd0, 7'h00); chk("R10 soft off", conv_trig, 0);
      pulse(1); chk("R10 pacer off", conv_trig, 0);
      pulse(2); chk("R10 ext off", conv_trig, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule